// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block steers every transaction address in a system fabric to a destination target ID. It holds a small bank of programmable address windows. Each window has a control word (enable and target ID), a security word (write-secure attribute), and a pair of inclusive bounds in 1 MiB blocks. An address that no enabled window claims goes to a default target held in one global register. Software programs all of these through a simple word-addressed register bus. Reads are combinational from the current register address.

Window 0 is kept for internal configuration-space access. It leaves reset enabled, with bounds and target taken from parameters, and software cannot change it. The decode path takes one request per cycle: an address, a write flag and a secure flag. One cycle later it returns the routed target, the matching window index, a hit flag and a security-violation flag.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset, windows 1 to NUM_WIN-1 are disabled with all fields zero, and the default target is 0. Window 0 is enabled with target WIN0_TID and bounds WIN0_LOW_BLK and WIN0_HIGH_BLK (defaults 0xA, 0xF00, 0xF0F).
- R2: Register map, with byte offsets and bits [1:0] of the offset ignored:
  - The registers of window n sit at 0x10·n. Offset +0x0 is control: bit 0 is enable and bits [7:4] are the target ID. Offset +0x4 is security: bit 0 is write-secure. Offset +0x8 is the low bound and +0xC the high bound; in both, bits [31:4] hold address bits [47:20].
  - The default target is at 0x100, in bits [3:0].
  - Bits not listed read 0. Unmapped offsets read 0, and writes to them are ignored.
- R3: A window matches when it is enabled and low ≤ addr[47:20] ≤ high, compared unsigned. Both bounds are inclusive, and address bits [19:0] play no part.
- R4: A window whose enable bit is clear never matches, whatever its bounds.
- R5: On a hit, rsp_target is the target ID field of the matching window and rsp_win is its index.
- R6: When several enabled windows match, the lowest-numbered one wins.
- R7: When no enabled window matches, rsp_hit is 0, rsp_win is 0 and rsp_target is the default target.
- R8: Register writes to window 0 (offsets 0x00 to 0x0F) are ignored. Its readback and its decode stay at the reset values.
- R9: rsp_viol is 1 only for a non-secure write (req_write=1, req_secure=0) that hits a window whose write-secure bit is set. Reads, secure writes and misses never flag.
- R10: A request presented with req_valid in one cycle yields rsp_valid=1 and its results in the next cycle. With req_valid low, rsp_valid drops and the other outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | Request is a write |
| req_secure | input | 1 | Request is secure |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_target | output | TID_W | Routed target ID |
| rsp_win | output | clog2(NUM_WIN) | Index of the winning window (0 on a miss) |
| rsp_hit | output | 1 | Some enabled window matched |
| rsp_viol | output | 1 | Write-secure violation |

## Verification
Some properties are checked on every cycle:
- the one-cycle response timing and the holding of outputs while idle;
- that the priority grant is at most one-hot;
- that a miss always carries the default target sampled with the request;
- that a violation only follows a non-secure write that hit;
- that window 0's registers never change after reset.

Other behaviour only the bench scenarios can show:
- the inclusive edges of the bounds, including single-block windows and the top of the address space;
- that overlapping windows resolve by index;
- that a disabled window falls through to the next match;
- the masking of register fields on readback.

// File: rtl/awd_pkg.sv
// Package: shared field positions and register kinds for the address
// window decoder. Assumes a 32-bit register bus with word-aligned offsets.
package awd_pkg;
    // Register kind inside one window's 16-byte slot, selected by offset bits [3:2]
    typedef enum logic [1:0] {
        RK_CTRL = 2'd0,
        RK_SEC  = 2'd1,
        RK_LOW  = 2'd2,
        RK_HIGH = 2'd3
    } reg_kind_e;

    localparam int unsigned REG_AW       = 9;   // register byte offset width
    localparam int unsigned REG_DW       = 32;  // register data width
    localparam int unsigned CTRL_EN_BIT  = 0;   // enable bit in control word
    localparam int unsigned CTRL_TID_LSB = 4;   // target ID lsb in control word
    localparam int unsigned SEC_WS_BIT   = 0;   // write-secure bit in security word
    localparam int unsigned BOUND_LSB    = 4;   // block number lsb in bound words
    localparam int unsigned BLK_SHIFT    = 20;  // 1 MiB granule
    localparam logic [REG_AW-1:2] GLOBAL_WORD = 7'h40; // default-target word (0x100)
endpackage

// File: rtl/awd_win_regs.sv
// Module: register file for all windows and the default target.
// Holds per-window enable, target ID, write-secure bit and inclusive
// low/high block bounds. Window 0 resets to parameter values and ignores
// writes. Reads are combinational from reg_addr. Assumes NUM_WIN <= 16,
// TID_W <= 4 and BLK_W <= 28.
module awd_win_regs
    import awd_pkg::*;
#(
    parameter int unsigned NUM_WIN      = 8,
    parameter int unsigned TID_W        = 4,
    parameter int unsigned BLK_W        = 28,
    parameter logic [31:0] WIN0_LOW_BLK  = 32'h0000_0F00,
    parameter logic [31:0] WIN0_HIGH_BLK = 32'h0000_0F0F,
    parameter logic [31:0] WIN0_TID      = 32'h0000_000A
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [REG_AW-1:0]              addr,
    input  logic [REG_DW-1:0]              wdata,
    output logic [REG_DW-1:0]              rdata,
    output logic [NUM_WIN-1:0]             win_en,
    output logic [NUM_WIN-1:0]             win_ws,
    output logic [NUM_WIN-1:0][TID_W-1:0]  win_tid,
    output logic [NUM_WIN-1:0][BLK_W-1:0]  win_low,
    output logic [NUM_WIN-1:0][BLK_W-1:0]  win_high,
    output logic [TID_W-1:0]               dflt_tid
);
    localparam int unsigned SEL_W = 4;

    logic [SEL_W-1:0] win_sel;
    reg_kind_e        kind;
    logic             in_win;
    logic             is_glob;

    // Decode the register offset into window index, register kind and region
    always_comb begin
        win_sel = addr[7:4];
        kind    = reg_kind_e'(addr[3:2]);
        in_win  = !addr[8] && (int'(win_sel) < int'(NUM_WIN));
        is_glob = (addr[REG_AW-1:2] == GLOBAL_WORD);
    end

    // Per-window storage; window 0 takes its reset values from parameters
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic             RST_EN   = (g == 0);
        localparam logic [TID_W-1:0] RST_TID  = (g == 0) ? WIN0_TID[TID_W-1:0] : '0;
        localparam logic [BLK_W-1:0] RST_LOW  = (g == 0) ? WIN0_LOW_BLK[BLK_W-1:0] : '0;
        localparam logic [BLK_W-1:0] RST_HIGH = (g == 0) ? WIN0_HIGH_BLK[BLK_W-1:0] : '0;
        localparam logic             WR_OK    = (g != 0);

        logic we;
        assign we = WR_OK && wr_en && in_win && (int'(win_sel) == g);

        // Update the addressed field of this window on a permitted write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_en[g]   <= RST_EN;
                win_ws[g]   <= 1'b0;
                win_tid[g]  <= RST_TID;
                win_low[g]  <= RST_LOW;
                win_high[g] <= RST_HIGH;
            end else if (we) begin
                case (kind)
                    RK_CTRL: begin
                        win_en[g]  <= wdata[CTRL_EN_BIT];
                        win_tid[g] <= wdata[CTRL_TID_LSB +: TID_W];
                    end
                    RK_SEC:  win_ws[g]   <= wdata[SEC_WS_BIT];
                    RK_LOW:  win_low[g]  <= wdata[BOUND_LSB +: BLK_W];
                    RK_HIGH: win_high[g] <= wdata[BOUND_LSB +: BLK_W];
                    default: ;
                endcase
            end
        end
    end

    // Default target register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dflt_tid <= '0;
        end else if (wr_en && is_glob) begin
            dflt_tid <= wdata[TID_W-1:0];
        end
    end

    // Readback mux; unlisted bits and unmapped offsets read zero
    always_comb begin
        rdata = '0;
        if (is_glob) begin
            rdata[TID_W-1:0] = dflt_tid;
        end else if (in_win) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (int'(win_sel) == i) begin
                    case (kind)
                        RK_CTRL: begin
                            rdata[CTRL_EN_BIT]              = win_en[i];
                            rdata[CTRL_TID_LSB +: TID_W]    = win_tid[i];
                        end
                        RK_SEC:  rdata[SEC_WS_BIT]           = win_ws[i];
                        RK_LOW:  rdata[BOUND_LSB +: BLK_W]   = win_low[i];
                        RK_HIGH: rdata[BOUND_LSB +: BLK_W]   = win_high[i];
                        default: ;
                    endcase
                end
            end
        end
    end

    // R8
    win0_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable({win_en[0], win_ws[0], win_tid[0], win_low[0], win_high[0]}));

endmodule

// File: rtl/awd_win_match.sv
// Module: parallel range comparators, one per window. A window reports a
// match when enabled and its inclusive low/high block bounds contain the
// request block number. Purely combinational; comparison is unsigned.
module awd_win_match #(
    parameter int unsigned NUM_WIN = 8,
    parameter int unsigned BLK_W   = 28
) (
    input  logic [BLK_W-1:0]              blk,
    input  logic [NUM_WIN-1:0]            win_en,
    input  logic [NUM_WIN-1:0][BLK_W-1:0] win_low,
    input  logic [NUM_WIN-1:0][BLK_W-1:0] win_high,
    output logic [NUM_WIN-1:0]            hit_vec
);
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        logic ge_low;
        logic le_high;
        // Compare the request block against both inclusive bounds
        always_comb begin
            ge_low     = (blk >= win_low[g]);
            le_high    = (blk <= win_high[g]);
            hit_vec[g] = win_en[g] && ge_low && le_high;
        end
    end
endmodule

// File: rtl/awd_prio_enc.sv
// Module: fixed-priority encoder, lowest index wins. Produces a one-hot
// grant, the winning index (0 when nothing requests) and an any flag.
module awd_prio_enc #(
    parameter int unsigned N   = 8,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan from the highest index down so the lowest requester is kept last
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx   = IDX_W'(i);
                any   = 1'b1;
            end
        end
    end

    // R6
    always_comb begin
        if (!$isunknown(req)) begin
            grant_onehot_chk: assert ($onehot0(grant) && (any == (|req)));
        end
    end
endmodule

// File: rtl/addr_win_decoder.sv
// Module: top of the programmable address window decoder. Combines the
// register file, the per-window comparators and the priority encoder, then
// registers the routed target, window index, hit and violation flags with
// one cycle of latency. Outputs hold while no request is presented.
// Assumes ADDR_W > 20, ADDR_W - 20 <= 28, 2 <= NUM_WIN <= 16, TID_W <= 4.
module addr_win_decoder
    import awd_pkg::*;
#(
    parameter int unsigned NUM_WIN       = 8,
    parameter int unsigned ADDR_W        = 48,
    parameter int unsigned TID_W         = 4,
    parameter logic [31:0] WIN0_LOW_BLK  = 32'h0000_0F00,
    parameter logic [31:0] WIN0_HIGH_BLK = 32'h0000_0F0F,
    parameter logic [31:0] WIN0_TID      = 32'h0000_000A,
    localparam int unsigned WIN_IW       = $clog2(NUM_WIN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [8:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic                 req_secure,
    output logic                 rsp_valid,
    output logic [TID_W-1:0]     rsp_target,
    output logic [WIN_IW-1:0]    rsp_win,
    output logic                 rsp_hit,
    output logic                 rsp_viol
);
    localparam int unsigned BLK_W = ADDR_W - BLK_SHIFT;

    logic [NUM_WIN-1:0]            win_en;
    logic [NUM_WIN-1:0]            win_ws;
    logic [NUM_WIN-1:0][TID_W-1:0] win_tid;
    logic [NUM_WIN-1:0][BLK_W-1:0] win_low;
    logic [NUM_WIN-1:0][BLK_W-1:0] win_high;
    logic [TID_W-1:0]              dflt_tid;

    logic [BLK_W-1:0]   req_blk;
    logic [NUM_WIN-1:0] hit_vec;
    logic [NUM_WIN-1:0] grant;
    logic [WIN_IW-1:0]  win_idx;
    logic               any_hit;
    logic [TID_W-1:0]   next_tid;
    logic               next_viol;

    awd_win_regs #(
        .NUM_WIN      (NUM_WIN),
        .TID_W        (TID_W),
        .BLK_W        (BLK_W),
        .WIN0_LOW_BLK (WIN0_LOW_BLK),
        .WIN0_HIGH_BLK(WIN0_HIGH_BLK),
        .WIN0_TID     (WIN0_TID)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .win_en  (win_en),
        .win_ws  (win_ws),
        .win_tid (win_tid),
        .win_low (win_low),
        .win_high(win_high),
        .dflt_tid(dflt_tid)
    );

    assign req_blk = req_addr[ADDR_W-1:BLK_SHIFT];

    awd_win_match #(
        .NUM_WIN(NUM_WIN),
        .BLK_W  (BLK_W)
    ) u_match (
        .blk     (req_blk),
        .win_en  (win_en),
        .win_low (win_low),
        .win_high(win_high),
        .hit_vec (hit_vec)
    );

    awd_prio_enc #(
        .N    (NUM_WIN),
        .IDX_W(WIN_IW)
    ) u_prio (
        .req  (hit_vec),
        .grant(grant),
        .idx  (win_idx),
        .any  (any_hit)
    );

    // Select the routed target and evaluate the write-secure rule
    always_comb begin
        next_tid  = dflt_tid;
        next_viol = 1'b0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (grant[i]) begin
                next_tid  = win_tid[i];
                next_viol = win_ws[i] && req_write && !req_secure;
            end
        end
    end

    // Register the decode result; hold it while no request is presented
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_target <= '0;
            rsp_win    <= '0;
            rsp_hit    <= 1'b0;
            rsp_viol   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_target <= next_tid;
                rsp_win    <= any_hit ? win_idx : '0;
                rsp_hit    <= any_hit;
                rsp_viol   <= next_viol;
            end
        end
    end

    // R10
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && $stable(rsp_target) && $stable(rsp_hit)
                       && $stable(rsp_win) && $stable(rsp_viol));

    // R9
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_viol |-> rsp_hit && $past(req_write && !req_secure));

    // R7
    miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> rsp_target == $past(dflt_tid) && rsp_win == '0);

endmodule

// File: tb/tb_addr_win_decoder.sv
`timescale 1ns/1ps
module tb_addr_win_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [47:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic        rsp_valid;
    logic [3:0]  rsp_target;
    logic [2:0]  rsp_win;
    logic        rsp_hit;
    logic        rsp_viol;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    addr_win_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_secure(req_secure),
        .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_win(rsp_win),
        .rsp_hit(rsp_hit), .rsp_viol(rsp_viol)
    );

    typedef struct packed {
        logic [27:0] blk;
        logic [19:0] off;
        logic        wr;
        logic        sec;
        logic        hit;
        logic [2:0]  win;
        logic [3:0]  tid;
        logic        viol;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{28'h0000000, 20'h00000, 1'b0, 1'b0, 1'b1, 3'd1, 4'h1, 1'b0},
        '{28'h00007FF, 20'hFFFFF, 1'b1, 1'b0, 1'b1, 3'd1, 4'h1, 1'b1},
        '{28'h0000400, 20'h00000, 1'b1, 1'b1, 1'b1, 3'd1, 4'h1, 1'b0},
        '{28'h0000800, 20'h00000, 1'b0, 1'b0, 1'b1, 3'd3, 4'h3, 1'b0},
        '{28'h00008FF, 20'hFFFFF, 1'b1, 1'b0, 1'b1, 3'd3, 4'h3, 1'b0},
        '{28'h0000900, 20'h12345, 1'b1, 1'b0, 1'b1, 3'd4, 4'h4, 1'b1},
        '{28'h0000901, 20'h00000, 1'b0, 1'b0, 1'b0, 3'd0, 4'hC, 1'b0},
        '{28'h0000A80, 20'h00000, 1'b1, 1'b0, 1'b0, 3'd0, 4'hC, 1'b0},
        '{28'hFFFFFFF, 20'hFFFFF, 1'b0, 1'b0, 1'b1, 3'd6, 4'h6, 1'b0},
        '{28'hFFFFFFE, 20'h00000, 1'b0, 1'b0, 1'b0, 3'd0, 4'hC, 1'b0},
        '{28'h0000F08, 20'h00000, 1'b0, 1'b0, 1'b1, 3'd0, 4'hA, 1'b0},
        '{28'h0000F10, 20'h00000, 1'b1, 1'b0, 1'b1, 3'd7, 4'h7, 1'b0},
        '{28'h0000F90, 20'h00000, 1'b0, 1'b0, 1'b0, 3'd0, 4'hC, 1'b0},
        '{28'h0000EFF, 20'hFFFFF, 1'b0, 1'b0, 1'b0, 3'd0, 4'hC, 1'b0},
        '{28'h0000900, 20'h00000, 1'b1, 1'b1, 1'b1, 3'd4, 4'h4, 1'b0}
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic reg_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    // Present one request; return at the negedge after the capturing edge
    task automatic do_req(input logic [27:0] blk, input logic [19:0] off,
                          input logic wr, input logic sec);
        @(negedge clk);
        req_valid = 1'b1; req_addr = {blk, off}; req_write = wr; req_secure = sec;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic win_prog(input int n, input logic [31:0] ctrl, input logic [31:0] sec,
                            input logic [27:0] lo, input logic [27:0] hi);
        reg_wr(9'(n * 16 + 0), ctrl);
        reg_wr(9'(n * 16 + 4), sec);
        reg_wr(9'(n * 16 + 8), {lo, 4'h0});
        reg_wr(9'(n * 16 + 12), {hi, 4'h0});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] rd;
        logic [3:0]  held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state through readback and decode
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        reg_rd(9'h100, rd); check("R1 default target", rd, 32'h0);
        reg_rd(9'h030, rd); check("R1 window3 ctrl", rd, 32'h0);
        reg_rd(9'h03C, rd); check("R1 window3 high", rd, 32'h0);
        reg_rd(9'h000, rd); check("R1 window0 ctrl", rd, 32'h000000A1);
        reg_rd(9'h008, rd); check("R1 window0 low", rd, 32'h0000F000);
        reg_rd(9'h00C, rd); check("R1 window0 high", rd, 32'h0000F0F0);
        do_req(28'h123, 20'h0, 1'b0, 1'b0);
        check("R1 R7 miss hit", {31'd0, rsp_hit}, 32'd0);
        check("R1 R7 miss target", {28'd0, rsp_target}, 32'h0);
        do_req(28'hF0F, 20'hFFFFF, 1'b0, 1'b0);
        check("R1 window0 hit", {31'd0, rsp_hit}, 32'd1);
        check("R1 window0 target", {28'd0, rsp_target}, 32'hA);

        // R8: writes to window 0 ignored
        win_prog(0, 32'h0, 32'h1, 28'h0, 28'h0);
        reg_rd(9'h000, rd); check("R8 window0 ctrl kept", rd, 32'h000000A1);
        reg_rd(9'h004, rd); check("R8 window0 sec kept", rd, 32'h0);
        reg_rd(9'h008, rd); check("R8 window0 low kept", rd, 32'h0000F000);
        do_req(28'hF00, 20'h0, 1'b1, 1'b0);
        check("R8 window0 still decodes", {27'd0, rsp_hit, rsp_target}, 32'h1A);
        check("R8 window0 no viol", {31'd0, rsp_viol}, 32'd0);

        // Program the table's map
        win_prog(1, 32'h11, 32'h1, 28'h000, 28'h7FF);
        win_prog(2, 32'h21, 32'h0, 28'h400, 28'h4FF);
        win_prog(3, 32'h31, 32'h0, 28'h800, 28'h8FF);
        win_prog(4, 32'h41, 32'h1, 28'h900, 28'h900);
        win_prog(5, 32'h50, 32'h1, 28'hA00, 28'hAFF);
        win_prog(6, 32'h61, 32'h0, 28'hFFFFFFF, 28'hFFFFFFF);
        win_prog(7, 32'h71, 32'h0, 28'hF08, 28'hF8F);
        reg_wr(9'h100, 32'hC);

        // Table walk: R3 hit, R6 window, R5/R7 target, R9 violation
        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].blk, VECS[i].off, VECS[i].wr, VECS[i].sec);
            check($sformatf("R10 table[%0d] valid", i), {31'd0, rsp_valid}, 32'd1);
            check($sformatf("R3 R4 table[%0d] hit", i), {31'd0, rsp_hit}, {31'd0, VECS[i].hit});
            check($sformatf("R6 table[%0d] window", i), {29'd0, rsp_win}, {29'd0, VECS[i].win});
            check($sformatf("R5 R7 table[%0d] target", i), {28'd0, rsp_target}, {28'd0, VECS[i].tid});
            check($sformatf("R9 table[%0d] viol", i), {31'd0, rsp_viol}, {31'd0, VECS[i].viol});
        end

        // R10: idle cycle drops valid and holds results
        held = rsp_target;
        @(negedge clk);
        check("R10 idle valid", {31'd0, rsp_valid}, 32'd0);
        check("R10 idle target held", {28'd0, rsp_target}, {28'd0, held});

        // R4 R6: disabling window 1 lets window 2 claim the overlap
        reg_wr(9'h010, 32'h10);
        do_req(28'h400, 20'h0, 1'b1, 1'b0);
        check("R4 R6 fall-through window", {29'd0, rsp_win}, 32'd2);
        check("R4 R6 fall-through target", {28'd0, rsp_target}, 32'h2);
        check("R9 fall-through no viol", {31'd0, rsp_viol}, 32'd0);
        do_req(28'h000, 20'h0, 1'b1, 1'b0);
        check("R4 disabled window misses", {27'd0, rsp_hit, rsp_target}, 32'h0C);
        check("R9 miss no viol", {31'd0, rsp_viol}, 32'd0);

        // R2: field masking and unmapped offsets
        reg_rd(9'h010, rd); check("R2 ctrl readback", rd, 32'h10);
        reg_wr(9'h030, 32'hFFFFFFFF);
        reg_rd(9'h030, rd); check("R2 ctrl mask", rd, 32'h000000F1);
        reg_wr(9'h034, 32'hFFFFFFFF);
        reg_rd(9'h034, rd); check("R2 sec mask", rd, 32'h1);
        reg_wr(9'h038, 32'hFFFFFFFF);
        reg_rd(9'h038, rd); check("R2 low mask", rd, 32'hFFFFFFF0);
        reg_rd(9'h03B, rd); check("R2 offset bits 1:0 ignored", rd, 32'hFFFFFFF0);
        reg_wr(9'h100, 32'hFFFFFFFF);
        reg_rd(9'h100, rd); check("R2 default mask", rd, 32'hF);
        reg_wr(9'h180, 32'hFFFFFFFF);
        reg_rd(9'h180, rd); check("R2 unmapped reads zero", rd, 32'h0);
        reg_rd(9'h070, rd); check("R2 unmapped write no effect", rd, 32'h71);

        summary();
    end
endmodule